// File: doc/BRIEF.md
# Register-Mapped Serial Port with Atomic Bit Aliases

This block is a serial transmitter and receiver that sits on a simple word-addressed register bus. Software configures it through five registers: a mode register with the global enable, a combined status and control register, a transmit data port, a receive data port and a baud divider. The mode and status registers each have two extra addresses. A one written at the clear alias drops the matching bit. A one written at the set alias raises it. A zero written at either alias changes nothing. Software can therefore change one control bit without a read-modify-write sequence.

Characters are always sent and received as one start bit, eight data bits with the least significant bit first, no parity and one stop bit. An internal tick runs at sixteen times the bit rate and is derived from the divider register. An eight-entry FIFO sits on each side. Status shows transmit FIFO full and empty and whether any received character is waiting. A receive overrun is sticky: while it is set, arriving characters are discarded. Software can request a break, which holds the line low for one frame time. The break starts once the character already on the line has finished.

Top module: `sio_port`

## Requirements
- R1: After a synchronous reset, mode reads 0x0000, status reads 0x0100 (transmit FIFO empty only), the divider reads 0 and the serial output is high.
- R2: Register offsets are mode 0x00, status 0x10, transmit data 0x20, receive data 0x30 and divider 0x40. Each of mode and status has its clear alias at +0x4 and its set alias at +0x8. A one at an alias clears or sets the matching bit, and a zero leaves it unchanged. Mode bit 15 is the global enable.
- R3: Status bits are 12 receive enable, 11 break request, 10 transmit enable, 9 transmit FIFO full, 8 transmit FIFO empty, 1 receive overrun and 0 receive data waiting. Writes to bits 9, 8 and 0 through either alias have no effect.
- R4: With mode bit 15 and transmit enable both set, queued characters leave in FIFO order as 8N1 frames, least significant bit first.
- R5: The transmit FIFO holds 8 characters. With 8 held, bit 9 reads one, and a further write to the transmit data port is discarded.
- R6: With mode bit 15 clear, the serial output stays high even when the transmit FIFO holds data.
- R7: A received frame sets bit 0. A read of the receive data port returns the oldest character in bits 7:0 and removes it. A read while the FIFO is empty returns 0.
- R8: A character that arrives while the receive FIFO is full sets bit 1 and is lost. While bit 1 is set, all arriving characters are discarded. A one written to bit 1 at the status clear alias resumes reception.
- R9: A set break request holds the output low for 10 bit times. The break starts after the character in progress ends and before any later queued character. The request bit then clears itself.
- R10: One bit lasts (divider + 1) × 16 clock cycles.
- R11: A low pulse on the receive input that is high again at mid-start-bit is ignored.
- R12: A direct write of 0 to status clears both enables, break and overrun, and empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; read data appears on the next cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_o | output | 1 | Serial output, high when idle |
| rx_i | input | 1 | Serial input |

## Verification
Two cases are made to coincide. In the first, a break request meets a transmitter that is partway through a character and still has another character queued. The bench writes the break bit as soon as the line falls for the first character. The scoreboard then expects that character, a full low frame and the queued character, in that order. In the second, an arriving character meets a receive FIFO that is already full. The bench sends nine and then ten characters without reading any. It checks that the overrun bit is set, that exactly the first eight come back in order, and that reception resumes only after the clear-alias write.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_TXD  = 8'h20;
  localparam logic [7:0] OFS_RXD  = 8'h30;
  localparam logic [7:0] OFS_BRG  = 8'h40;
  localparam logic [7:0] ALIAS_CLR = 8'h04;
  localparam logic [7:0] ALIAS_SET = 8'h08;

  localparam int unsigned B_ON    = 15;
  localparam int unsigned B_RXEN  = 12;
  localparam int unsigned B_BRK   = 11;
  localparam int unsigned B_TXEN  = 10;
  localparam int unsigned B_FULL  = 9;
  localparam int unsigned B_EMPTY = 8;
  localparam int unsigned B_OVR   = 1;
  localparam int unsigned B_AVAIL = 0;

  localparam int unsigned OVS     = 16;
  localparam int unsigned FRAME_B = 10;

  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_BREAK} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int unsigned BW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [BW-1:0] div,
  output logic          tick
);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  input  logic       brk_req,
  output logic       q_pop,
  output logic       brk_done,
  output logic       brk_busy,
  output logic       line
);
  localparam int unsigned SUB_W = $clog2(OVS);
  localparam int unsigned BIT_W = $clog2(FRAME_B);

  tx_state_e        st;
  logic [SUB_W-1:0] sub;
  logic [BIT_W-1:0] bitn;
  logic [8:0]       sh;
  logic             bit_end, last_bit, start_brk;

  assign bit_end   = tick && (sub == SUB_W'(OVS - 1));
  assign last_bit  = (bitn == BIT_W'(FRAME_B - 1));
  assign start_brk = en && tick && (st == TX_IDLE) && brk_req;
  assign q_pop     = en && tick && (st == TX_IDLE) && !brk_req && !q_empty;
  assign brk_done  = en && (st == TX_BREAK) && bit_end && last_bit;
  assign brk_busy  = (st == TX_BREAK);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st   <= TX_IDLE;
      line <= 1'b1;
      sub  <= '0;
      bitn <= '0;
      sh   <= '1;
    end else begin
      unique case (st)
        TX_IDLE: begin
          sub  <= '0;
          bitn <= '0;
          if (start_brk) begin
            st   <= TX_BREAK;
            line <= 1'b0;
          end else if (q_pop) begin
            st   <= TX_SHIFT;
            sh   <= {1'b1, q_data};
            line <= 1'b0;
          end
        end
        TX_SHIFT: begin
          if (tick) sub <= sub + 1'b1;
          if (bit_end) begin
            if (last_bit) begin
              st   <= TX_IDLE;
              line <= 1'b1;
            end else begin
              line <= sh[0];
              sh   <= {1'b1, sh[8:1]};
              bitn <= bitn + 1'b1;
            end
          end
        end
        TX_BREAK: begin
          if (tick) sub <= sub + 1'b1;
          if (bit_end) begin
            if (last_bit) begin
              st   <= TX_IDLE;
              line <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       rx,
  output logic       valid,
  output logic [7:0] data
);
  localparam int unsigned SUB_W = $clog2(OVS);

  rx_state_e        st;
  logic [SUB_W-1:0] sub;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st    <= RX_IDLE;
      sub   <= '0;
      bitn  <= '0;
      sh    <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: begin
            sub  <= '0;
            bitn <= '0;
            if (!rx) st <= RX_START;
          end
          RX_START: begin
            if (sub == SUB_W'(OVS / 2 - 1)) begin
              sub <= '0;
              st  <= rx ? RX_IDLE : RX_DATA;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_DATA: begin
            sub <= sub + 1'b1;
            if (sub == SUB_W'(OVS - 1)) begin
              sh <= {rx, sh[7:1]};
              if (bitn == 3'd7) st <= RX_STOP;
              else              bitn <= bitn + 1'b1;
            end
          end
          RX_STOP: begin
            sub <= sub + 1'b1;
            if (sub == SUB_W'(OVS - 1)) begin
              st    <= RX_IDLE;
              valid <= rx;
              data  <= sh;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned BRG_W    = 16,
  parameter int unsigned BRG_INIT = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        tx_o,
  input  logic        rx_i
);
  logic             mode_on, rx_en, tx_en, brk_q, ovr_q;
  logic [BRG_W-1:0] brg;
  logic [1:0]       rx_sync;

  logic wr_mode, wr_mode_clr, wr_mode_set;
  logic wr_stat, wr_stat_clr, wr_stat_set;
  logic wr_txd, wr_brg, rd_rxd;

  assign wr_mode     = wr_en && (addr == OFS_MODE);
  assign wr_mode_clr = wr_en && (addr == (OFS_MODE | ALIAS_CLR));
  assign wr_mode_set = wr_en && (addr == (OFS_MODE | ALIAS_SET));
  assign wr_stat     = wr_en && (addr == OFS_STAT);
  assign wr_stat_clr = wr_en && (addr == (OFS_STAT | ALIAS_CLR));
  assign wr_stat_set = wr_en && (addr == (OFS_STAT | ALIAS_SET));
  assign wr_txd      = wr_en && (addr == OFS_TXD);
  assign wr_brg      = wr_en && (addr == OFS_BRG);
  assign rd_rxd      = rd_en && (addr == OFS_RXD);

  // next value of a software bit: direct write, then set alias, then clear alias
  function automatic logic sw_bit(input logic cur, input logic dir, input logic set_w,
                                  input logic clr_w, input logic val);
    if (dir)               return val;
    else if (set_w && val) return 1'b1;
    else if (clr_w && val) return 1'b0;
    else                   return cur;
  endfunction

  // shared tick and FIFOs
  logic tick, tx_run, rx_run;
  logic tx_full, tx_empty, tx_pop;
  logic [7:0] tx_head;
  logic rx_full, rx_empty, rx_valid, rx_push, rx_take;
  logic [7:0] rx_head, rx_data;
  logic brk_done, brk_busy, fifo_flush, ovr_clr_req;

  assign tx_run      = mode_on && tx_en;
  assign rx_run      = mode_on && rx_en;
  assign fifo_flush  = wr_stat;
  assign rx_take     = rx_valid && !ovr_q;
  assign rx_push     = rx_take && !rx_full;
  assign ovr_clr_req = (wr_stat && !wdata[B_OVR]) || (wr_stat_clr && wdata[B_OVR]);

  sio_baud #(.BW(BRG_W)) u_baud (
    .clk(clk), .rst(rst), .en(mode_on), .div(brg), .tick(tick)
  );

  sio_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(fifo_flush),
    .push(wr_txd), .din(wdata[7:0]), .pop(tx_pop),
    .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  sio_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(fifo_flush),
    .push(rx_push), .din(rx_data), .pop(rd_rxd),
    .dout(rx_head), .full(rx_full), .empty(rx_empty)
  );

  sio_tx u_tx (
    .clk(clk), .rst(rst), .en(tx_run), .tick(tick),
    .q_empty(tx_empty), .q_data(tx_head), .brk_req(brk_q),
    .q_pop(tx_pop), .brk_done(brk_done), .brk_busy(brk_busy), .line(tx_o)
  );

  sio_rx u_rx (
    .clk(clk), .rst(rst), .en(rx_run), .tick(tick),
    .rx(rx_sync[1]), .valid(rx_valid), .data(rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], rx_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_on <= 1'b0;
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      brk_q   <= 1'b0;
      ovr_q   <= 1'b0;
      brg     <= BRG_W'(BRG_INIT);
    end else begin
      mode_on <= sw_bit(mode_on, wr_mode, wr_mode_set, wr_mode_clr, wdata[B_ON]);
      rx_en   <= sw_bit(rx_en, wr_stat, wr_stat_set, wr_stat_clr, wdata[B_RXEN]);
      tx_en   <= sw_bit(tx_en, wr_stat, wr_stat_set, wr_stat_clr, wdata[B_TXEN]);
      brk_q   <= sw_bit(brk_q && !brk_done, wr_stat, wr_stat_set, wr_stat_clr, wdata[B_BRK]);
      if (rx_take && rx_full) ovr_q <= 1'b1;
      else ovr_q <= sw_bit(ovr_q, wr_stat, wr_stat_set, wr_stat_clr, wdata[B_OVR]);
      if (wr_brg) brg <= wdata[BRG_W-1:0];
    end
  end

  logic [31:0] stat_word;
  always_comb begin
    stat_word          = '0;
    stat_word[B_RXEN]  = rx_en;
    stat_word[B_BRK]   = brk_q;
    stat_word[B_TXEN]  = tx_en;
    stat_word[B_FULL]  = tx_full;
    stat_word[B_EMPTY] = tx_empty;
    stat_word[B_OVR]   = ovr_q;
    stat_word[B_AVAIL] = !rx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (addr)
        OFS_MODE: rdata <= 32'(mode_on) << B_ON;
        OFS_STAT: rdata <= stat_word;
        OFS_RXD:  rdata <= rx_empty ? 32'd0 : {24'd0, rx_head};
        OFS_BRG:  rdata <= 32'(brg);
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic clk,
  input logic rst,
  input logic tx_o,
  input logic mode_on,
  input logic tx_full,
  input logic tx_pop,
  input logic flush,
  input logic ovr_q,
  input logic ovr_clr_req,
  input logic rx_push,
  input logic brk_busy
);
  // R6
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_on |=> tx_o);

  // R5
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !tx_pop && !flush) |=> tx_full);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !ovr_clr_req) |=> ovr_q);

  // R8
  ovr_block_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_q |-> !rx_push);

  // R9
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    brk_busy |-> !tx_o);
endmodule

bind sio_port sio_port_chk i_chk (
  .clk(clk), .rst(rst), .tx_o(tx_o), .mode_on(mode_on),
  .tx_full(tx_full), .tx_pop(tx_pop), .flush(fifo_flush),
  .ovr_q(ovr_q), .ovr_clr_req(ovr_clr_req), .rx_push(rx_push),
  .brk_busy(brk_busy)
);

// File: tb/test_sio_port.sv
module test_sio_port;
  localparam int BIT = 32;          // divider 1 -> (1+1)*16 clocks
  localparam int BRK_ITEM = 'h100;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, rx_i = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_o;

  sio_port i_sio_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_o(tx_o), .rx_i(rx_i)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int exp_q[$];
  logic done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rx_i = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx_i = 1'b1;
    repeat (BIT + 4) @(negedge clk);
  endtask

  task automatic drain_tx();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (BIT * 12) @(negedge clk);
  endtask

  // scoreboard monitor on the serial output (R4, R9, R10 timing)
  initial begin
    forever begin
      @(negedge clk);
      if (tx_o === 1'b0) begin
        int val;
        logic stop;
        val = 0;
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          val[i] = tx_o;
        end
        repeat (BIT) @(negedge clk);
        stop = tx_o;
        if (!stop && val == 0) begin
          val = BRK_ITEM;
          while (tx_o !== 1'b1) @(negedge clk);
        end
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected frame actual=%h expected=none", val);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (val != e) begin
            fails++;
            $display("FAIL R4/R9 frame actual=%h expected=%h", val, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lowcnt;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h10, d); chk("R1 status", d, 32'h100);
    rd(8'h00, d); chk("R1 mode", d, 32'h0);
    rd(8'h40, d); chk("R1 divider", d, 32'h0);
    chk("R1 line", tx_o, 1'b1);

    // R2 aliases on mode
    wr(8'h08, 32'h8000); rd(8'h00, d); chk("R2 set alias", d, 32'h8000);
    wr(8'h04, 32'h0000); rd(8'h00, d); chk("R2 zero at clear alias", d, 32'h8000);
    wr(8'h04, 32'h8000); rd(8'h00, d); chk("R2 clear alias", d, 32'h0);
    wr(8'h40, 32'd1);    rd(8'h40, d); chk("R10 divider", d, 32'd1);

    // R3 read-only bits ignore alias writes
    wr(8'h18, 32'h301); rd(8'h10, d); chk("R3 set alias on RO bits", d, 32'h100);
    wr(8'h14, 32'h100); rd(8'h10, d); chk("R3 clear alias on RO bits", d, 32'h100);

    // R6 gating: transmit enabled, global enable off
    wr(8'h18, 32'h400);
    wr(8'h20, 32'h41);
    exp_q.push_back('h41);
    lowcnt = 0;
    repeat (3 * BIT) begin
      @(negedge clk);
      if (tx_o !== 1'b1) lowcnt++;
    end
    chk("R6 line held high", lowcnt, 0);
    rd(8'h10, d); chk("R6 status not empty", d, 32'h400);

    // R5 fill the FIFO, ninth write dropped
    for (int i = 1; i < 9; i++) begin
      wr(8'h20, 32'(8'h10 + i));
      if (i < 8) exp_q.push_back(8'h10 + i);
    end
    rd(8'h10, d); chk("R5 full", d, 32'h600);

    // R4 drain in order
    wr(8'h08, 32'h8000);
    drain_tx();
    rd(8'h10, d); chk("R4 empty after drain", d, 32'h500);

    // R10 start bit duration, R4 another pattern
    exp_q.push_back('h01);
    exp_q.push_back('hA5);
    wr(8'h20, 32'h01);
    wr(8'h20, 32'hA5);
    while (tx_o !== 1'b0) @(negedge clk);
    lowcnt = 0;
    while (tx_o === 1'b0) begin lowcnt++; @(negedge clk); end
    chk("R10 start bit length", lowcnt, BIT);
    drain_tx();

    // R9 break requested mid-character, with a character still queued
    exp_q.push_back('h3C);
    exp_q.push_back(BRK_ITEM);
    exp_q.push_back('h5A);
    wr(8'h20, 32'h3C);
    wr(8'h20, 32'h5A);
    while (tx_o !== 1'b0) @(negedge clk);
    wr(8'h18, 32'h800);
    drain_tx();
    rd(8'h10, d); chk("R9 request self-clears", d, 32'h500);

    // R7 receive and pop
    wr(8'h18, 32'h1000);
    send_rx(8'hC3);
    rd(8'h10, d); chk("R7 data waiting", d, 32'h1501);
    rd(8'h30, d); chk("R7 read data", d, 32'hC3);
    rd(8'h10, d); chk("R7 no data after pop", d, 32'h1500);
    rd(8'h30, d); chk("R7 empty read", d, 32'h0);

    // R11 short low pulse rejected
    @(negedge clk); rx_i = 1'b0;
    repeat (8) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    rd(8'h10, d); chk("R11 glitch ignored", d, 32'h1500);

    // R8 overrun, sticky, recovery
    for (int i = 0; i < 9; i++) send_rx(8'(i * 17 + 1));
    rd(8'h10, d); chk("R8 overrun set", d, 32'h1503);
    send_rx(8'hEE);
    for (int i = 0; i < 8; i++) begin
      rd(8'h30, d); chk("R8 kept order", d, 32'(8'(i * 17 + 1)));
    end
    rd(8'h10, d); chk("R8 lost while set", d, 32'h1502);
    wr(8'h14, 32'h2); rd(8'h10, d); chk("R8 clear alias", d, 32'h1500);
    send_rx(8'h77);
    rd(8'h30, d); chk("R8 resumed", d, 32'h77);

    // R12 direct write of zero flushes
    wr(8'h14, 32'h400);
    wr(8'h20, 32'h11);
    send_rx(8'h22);
    wr(8'h18, 32'h2);
    rd(8'h10, d); chk("R12 before flush", d, 32'h1003);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R12 after flush", d, 32'h100);
    rd(8'h30, d); chk("R12 rx emptied", d, 32'h0);
    wr(8'h18, 32'h400);
    repeat (BIT * 24) @(negedge clk);
    rd(8'h10, d); chk("R12 tx emptied", d, 32'h500);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule